// File: doc/BRIEF.md
# Transmit Descriptor Status Capture

This block watches three printer-side status lines while one transmit buffer is being sent. It then builds the status/control word that is written back into that buffer's descriptor when the buffer closes. The three lines are a fault line, a paper-error line and a select line. The fault and paper-error lines report trouble when they are high. The select line reports trouble when it is low. Each condition is held as a sticky flag for the whole transmission window of a buffer. A window opens on a one-cycle `buf_start` strobe and closes on a one-cycle `buf_end` strobe.

The status lines are asynchronous to `clk`, so each one passes through a two-flop synchronizer before it is sampled. The window covers every clock edge from the one that sees `buf_start` up to and including the one that sees `buf_end`. The synchronized line values seen at any of those edges count toward the buffer.

The write-back is a plain one-cycle strobe, `wb_valid`, with `wb_word`. There is no ready input and no back-pressure: the descriptor writer must take the word in the cycle `wb_valid` is high. `wb_word` keeps its last value between write-backs.

Word bits are numbered with bit 0 as the most significant bit, so numbered bit n sits at `wb_word[15-n]`.

Top module: `txbd_status_capture`

## Requirements
- R1: The fault bit (numbered 12, `wb_word[3]`) is 1 in a write-back if the synchronized fault line was high at any clock edge of that buffer's window, and 0 if it stayed low.
- R2: The paper-error bit (numbered 13, `wb_word[2]`) is 1 if the synchronized paper-error line was high at any edge of the window, and 0 otherwise.
- R3: The select-error bit (numbered 14, `wb_word[1]`) is 1 if the synchronized select line was low at any edge of the window. It is 0 only when select stayed high for the whole window.
- R4: In every write-back, the ready bit (numbered 0, `wb_word[15]`), the reserved bit (numbered 15, `wb_word[0]`) and all bits other than bits 12 to 14 are 0.
- R5: `buf_start` discards the flags of any earlier buffer, so a buffer with no line activity writes back `16'h0000` even if the previous buffer had errors.
- R6: A change on a status line counts from the third rising edge after the change. A line raised two steps before the `buf_end` step is included; a line raised one step before it is not.
- R7: `wb_valid` is high for exactly the one cycle after the edge that samples `buf_end` of an open window. The word includes the line values sampled at that same edge.
- R8: A `buf_end` that arrives when no window is open, and without `buf_start`, produces no write-back.
- R9: `buf_start` and `buf_end` in the same cycle form a one-edge window. It writes back the conditions sampled at that single edge.
- R10: A `buf_start` that arrives while a window is open restarts the window and drops the flags gathered so far.
- R11: While `rst_n` is low, `wb_valid` and `wb_word` are 0 and no window is open. The synchronizers take the idle (no-error) line levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_start | input | 1 | One-cycle strobe: transmission of a buffer begins |
| buf_end | input | 1 | One-cycle strobe: the buffer is closed |
| fault_line | input | 1 | Asynchronous fault status, high means fault |
| paper_err_line | input | 1 | Asynchronous paper-error status, high means error |
| select_line | input | 1 | Asynchronous select status, low means deselected |
| wb_valid | output | 1 | One-cycle write-back strobe |
| wb_word | output | 16 | Formatted status/control word, numbered bit 0 at MSB |

## Verification
A status line driven at one step reaches the flags only at the third rising edge that follows. A strobe driven at one step acts on the very next edge. The resulting `wb_valid` and `wb_word` are visible from that edge for one cycle. The bench therefore drives inputs on falling edges and advances a behavioural model, with its own two-deep line delay, on every rising edge. It compares both outputs at the next falling edge. Directed checks read the write-back at the falling edge after the `buf_end` step. They place line changes one and two steps before that step to pin down where the window boundary falls.

// File: rtl/tdsc_pkg.sv
package tdsc_pkg;
  // word geometry; numbered bit 0 is the most significant bit
  localparam int WORD_W = 16;
  localparam int NLINES = 3;

  // line indices
  localparam int LN_FAULT = 0;
  localparam int LN_PERR  = 1;
  localparam int LN_SEL   = 2;

  // lines whose error condition is the low level
  localparam logic [NLINES-1:0] ERR_WHEN_LOW = 3'b100;

  // numbered positions in the status word
  localparam int NUM_READY     = 0;
  localparam int NUM_FIRST_ERR = 12;
  localparam int NUM_RSVD      = 15;

  function automatic int word_pos(input int num);
    return WORD_W - 1 - num;
  endfunction

  function automatic logic [WORD_W-1:0] err_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NLINES; i++) m[word_pos(NUM_FIRST_ERR + i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tdsc_sync.sv
module tdsc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] chain;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < STAGES; g++) chain[g] <= IDLE;
    end else begin
      chain[0] <= async_in;
      for (int g = 1; g < STAGES; g++) chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign sync_out = chain[STAGES-1];

  // R6: the last stage follows the one before it by exactly one edge
  a_r6_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (chain[STAGES-1] == $past(chain[STAGES-2])));
endmodule

// File: rtl/tdsc_window.sv
module tdsc_window #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_start,
  input  logic         buf_end,
  input  logic [N-1:0] err_now,
  output logic         open,
  output logic         fire,
  output logic [N-1:0] err_seen
);
  logic open_q;
  logic [N-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    open_q <= 1'b0;
    else if (buf_start && !buf_end) open_q <= 1'b1;
    else if (buf_end)              open_q <= 1'b0;
  end

  assign open = open_q;
  assign fire = buf_end && (open_q || buf_start);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic base;
    assign base        = buf_start ? 1'b0 : flag_q[i];
    assign err_seen[i] = base | err_now[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flag_q[i] <= 1'b0;
      else if (buf_start || open_q)  flag_q[i] <= err_seen[i];
    end

    // R1/R2/R3: a flag once set stays set until the window restarts
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !buf_start && !buf_end && flag_q[i]) |=> flag_q[i]);
  end

  // R10: a start without an end leaves the window open
  a_r10_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_start && !buf_end) |=> open_q);

  // R9: a start together with an end leaves the window closed
  a_r9_same_cycle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_start && buf_end) |=> !open_q);
endmodule

// File: rtl/tdsc_format.sv
module tdsc_format
  import tdsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [NLINES-1:0] err_seen,
  output logic              wb_valid,
  output logic [WORD_W-1:0] wb_word
);
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = '0;
    for (int i = 0; i < NLINES; i++) word_d[word_pos(NUM_FIRST_ERR + i)] = err_seen[i];
    word_d[word_pos(NUM_READY)] = 1'b0;
    word_d[word_pos(NUM_RSVD)]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_word  <= '0;
    end else begin
      wb_valid <= fire;
      if (fire) wb_word <= word_d;
    end
  end

  // R4: only the three error bits may ever be set in a write-back
  a_r4_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((wb_word & ~err_mask()) == '0));

  // R7: the word is held steady between write-backs
  a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(wb_word));
endmodule

// File: rtl/txbd_status_capture.sv
module txbd_status_capture
  import tdsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_start,
  input  logic              buf_end,
  input  logic              fault_line,
  input  logic              paper_err_line,
  input  logic              select_line,
  output logic              wb_valid,
  output logic [WORD_W-1:0] wb_word
);
  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] err_now;
  logic [NLINES-1:0] err_seen;
  logic              win_open;
  logic              fire;

  assign raw_lines[LN_FAULT] = fault_line;
  assign raw_lines[LN_PERR]  = paper_err_line;
  assign raw_lines[LN_SEL]   = select_line;

  tdsc_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .IDLE(ERR_WHEN_LOW)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_lines), .sync_out(synced));

  assign err_now = synced ^ ERR_WHEN_LOW;

  tdsc_window #(.N(NLINES)) u_win (
    .clk(clk), .rst_n(rst_n), .buf_start(buf_start), .buf_end(buf_end),
    .err_now(err_now), .open(win_open), .fire(fire), .err_seen(err_seen));

  tdsc_format u_fmt (
    .clk(clk), .rst_n(rst_n), .fire(fire), .err_seen(err_seen),
    .wb_valid(wb_valid), .wb_word(wb_word));

  // R7: a write-back always follows an end strobe by one edge
  a_r7_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(buf_end));

  // R8: an end with no open window and no start is dropped
  a_r8_idle_end: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_end && !buf_start && !win_open) |=> !wb_valid);
endmodule

// File: tb/txbd_status_capture_test.sv
module txbd_status_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_start = 1'b0, buf_end = 1'b0;
  logic fault_line = 1'b0, paper_err_line = 1'b0, select_line = 1'b1;
  logic wb_valid;
  logic [15:0] wb_word;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  txbd_status_capture uut (
    .clk(clk), .rst_n(rst_n), .buf_start(buf_start), .buf_end(buf_end),
    .fault_line(fault_line), .paper_err_line(paper_err_line),
    .select_line(select_line), .wb_valid(wb_valid), .wb_word(wb_word));

  // behavioural reference: two-deep line delay, window flag, sticky flags
  logic [2:0] dq [$];
  bit m_open;
  bit [2:0] m_flag;
  bit exp_valid;
  bit [15:0] exp_word;

  function automatic bit [15:0] fmt(input bit [2:0] e);
    bit [15:0] w = 16'h0000;
    if (e[0]) w = w | 16'h0008;
    if (e[1]) w = w | 16'h0004;
    if (e[2]) w = w | 16'h0002;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq = '{3'b100, 3'b100};
      m_open = 0; m_flag = '0; exp_valid = 0; exp_word = '0;
    end else begin
      bit [2:0] cond, live;
      bit fire;
      cond = dq[0] ^ 3'b100;
      fire = buf_end && (m_open || buf_start);
      live = (buf_start ? 3'b000 : m_flag) | cond;
      if (buf_start || m_open) m_flag = live;
      if (buf_start && !buf_end) m_open = 1;
      else if (buf_end) m_open = 0;
      exp_valid = fire;
      if (fire) exp_word = fmt(live);
      void'(dq.pop_front());
      dq.push_back({select_line, paper_err_line, fault_line});
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    string tag;
    check("R7", {15'd0, wb_valid}, {15'd0, exp_valid});
    if (wb_word[3] !== exp_word[3]) tag = "R1";
    else if (wb_word[2] !== exp_word[2]) tag = "R2";
    else if (wb_word[1] !== exp_word[1]) tag = "R3";
    else tag = "R4";
    check(tag, wb_word, exp_word);
  endtask

  // drive strobes for one edge, then compare at the following falling edge
  task automatic step(input bit s, input bit e);
    buf_start = s; buf_end = e;
    @(posedge clk);
    @(negedge clk);
    buf_start = 0; buf_end = 0;
    compare_model();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0);
  endtask

  task automatic expect_wb(input string req, input logic [15:0] w);
    check(req, {15'd0, wb_valid}, 16'd1);
    check(req, wb_word, w);
  endtask

  initial begin
    @(negedge clk);
    // R11: reset state
    check("R11", {15'd0, wb_valid}, 16'd0);
    check("R11", wb_word, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    idle(3);

    // R7/R4: clean buffer
    step(1, 0); idle(4); step(0, 1);
    expect_wb("R4", 16'h0000);
    step(0, 0);
    check("R7", {15'd0, wb_valid}, 16'd0);

    // R1: short fault pulse mid-window
    step(1, 0); fault_line = 1; step(0, 0); fault_line = 0; idle(4); step(0, 1);
    expect_wb("R1", 16'h0008);

    // R5: next buffer with no activity
    idle(2); step(1, 0); idle(4); step(0, 1);
    expect_wb("R5", 16'h0000);

    // R2: paper error pulse
    step(1, 0); paper_err_line = 1; step(0, 0); paper_err_line = 0; idle(4); step(0, 1);
    expect_wb("R2", 16'h0004);

    // R3: select briefly dropped
    idle(2); step(1, 0); select_line = 0; step(0, 0); select_line = 1; idle(4); step(0, 1);
    expect_wb("R3", 16'h0002);

    // all three together
    idle(2); step(1, 0); fault_line = 1; paper_err_line = 1; select_line = 0;
    step(0, 0); fault_line = 0; paper_err_line = 0; select_line = 1; idle(4); step(0, 1);
    expect_wb("R3", 16'h000E);

    // R6: raised one step before end is not included
    idle(3); step(1, 0); idle(2); fault_line = 1; step(0, 0); step(0, 1);
    expect_wb("R6", 16'h0000);
    fault_line = 0; idle(4);

    // R6/R7: raised two steps before end is included (end-edge sample)
    step(1, 0); idle(2); fault_line = 1; step(0, 0); step(0, 0); step(0, 1);
    expect_wb("R6", 16'h0008);
    fault_line = 0; idle(4);

    // R8: end with no open window
    step(0, 1);
    check("R8", {15'd0, wb_valid}, 16'd0);
    check("R8", wb_word, 16'h0008);

    // R9: one-edge window with paper error held
    paper_err_line = 1; idle(3); step(1, 1);
    expect_wb("R9", 16'h0004);
    paper_err_line = 0; idle(4);

    // R10: restart drops earlier fault
    step(1, 0); fault_line = 1; step(0, 0); fault_line = 0; idle(4);
    step(1, 0); idle(3); step(0, 1);
    expect_wb("R10", 16'h0000);

    // R11: reset while a window is open
    step(1, 0); idle(2);
    rst_n = 0;
    @(negedge clk);
    check("R11", {15'd0, wb_valid}, 16'd0);
    check("R11", wb_word, 16'h0000);
    rst_n = 1;
    idle(2); step(0, 1);
    check("R11", {15'd0, wb_valid}, 16'd0);
    idle(2);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule